// File: doc/BRIEF.md
# Sign-Guided Transition Bus Codec

This block lowers switching activity on a narrow data bus that carries two's complement samples split into bus-width pieces. Pieces holding the upper part of a sample are mostly all zeros or all ones because of sign extension. The encoder does not count ones to decide on inversion. Instead it uses the top bit of each incoming word as a guess. A zero top bit leaves the other bits as they are. A one top bit complements them. The top bit itself goes onto the bus as a plain level. The remaining bits are sent as transitions, each XORed with the value that line carried for the previous word. No extra invert wire is needed, so the bus is exactly as wide as the data.

The decoder on the far side reads the top bit straight from the bus. It XORs the other lines with the lower bits it received for the previous word, then complements the result when the top bit is one. Both ends keep a registered copy of the previous lower bus bits. That copy clears on synchronous reset and advances only on valid cycles. The encoder registers its bus output, and the decoder registers its data output, so each side adds one cycle. Only shallow XOR logic sits between each input and its register.

Top module: `abt_codec`

## Requirements
- R1: During and immediately after synchronous reset, `bus_out`, `bus_vld`, `dec_data` and `dec_vld` are all zero, and both previous-lower-bits stores are zero.
- R2: One cycle after a cycle with `enc_vld` high, `bus_out[W-1]` equals `enc_data[W-1]` from that cycle and `bus_vld` is high.
- R3: For an accepted word whose top bit is 0, the following cycle `bus_out[W-2:0]` equals `enc_data[W-2:0]` XOR the previous `bus_out[W-2:0]`.
- R4: For an accepted word whose top bit is 1, the following cycle `bus_out[W-2:0]` equals the complement of `enc_data[W-2:0]`, XORed with the previous `bus_out[W-2:0]`.
- R5: A cycle with `enc_vld` low leaves `bus_out` unchanged and drives `bus_vld` low the next cycle. The following valid word is still coded against the last driven bus value.
- R6: One cycle after `rx_vld` is high, `dec_vld` is high and `dec_data` holds the word the encoder was given. With `bus_out` looped to `rx_bus`, the round trip takes two cycles.
- R7: A cycle with `rx_vld` low holds `dec_data` and the decoder's stored lower bits, and drives `dec_vld` low the next cycle.
- R8: From reset, input 8'b00000101 drives bus 8'b00000101, and the next input 8'b10101111 drives 8'b11010101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_vld | input | 1 | Encoder input word valid |
| enc_data | input | W | Word to encode |
| bus_vld | output | 1 | Registered valid for the driven bus word |
| bus_out | output | W | Coded bus lines |
| rx_vld | input | 1 | Received bus word valid |
| rx_bus | input | W | Received coded bus lines |
| dec_vld | output | 1 | Decoded word valid |
| dec_data | output | W | Decoded word |

## Verification
The bench builds the codec with W = 8. At that width every one of the 256 input words can be swept in several orders: ascending, descending, with idle gaps and in pseudo-random order. It also feeds alternating sign-piece and fraction-piece sequences. This checks each bus word against an arithmetic model and reaches both guess outcomes from many previous bus states. The looped decoder is checked for exact recovery with two-cycle latency, including across idle cycles, where both ends must hold their stored lower bits.

// File: rtl/abt_pkg.sv
package abt_pkg;
    localparam int unsigned ABT_W_DEFAULT = 8;

    // Complement the lower part of a word when the guess bit is set.
    function automatic logic [63:0] abt_guess_flip(input logic [63:0] low, input logic guess);
        return guess ? ~low : low;
    endfunction
endpackage

// File: rtl/abt_encoder.sv
module abt_encoder
    import abt_pkg::*;
#(
    parameter int unsigned W = ABT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_bus
);
    localparam int unsigned LW = W - 1;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] bus;
    } enc_state_t;

    enc_state_t st_d, st_q;
    logic [LW-1:0] mid_low;
    logic [63:0]   flip_wide;

    always_comb begin
        flip_wide = abt_guess_flip(64'(in_data[LW-1:0]), in_data[W-1]);
        mid_low   = flip_wide[LW-1:0];
        st_d      = st_q;
        st_d.vld  = in_vld;
        if (in_vld) begin
            st_d.bus = {in_data[W-1], mid_low ^ st_q.bus[LW-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_bus = st_q.bus;

    // R2
    msb_level_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_bus[W-1] == $past(in_data[W-1])) && out_vld);
    // R3
    low_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_data[W-1]) |=> (out_bus[LW-1:0] ^ $past(out_bus[LW-1:0])) == $past(in_data[LW-1:0]));
    // R4
    low_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_data[W-1]) |=> (out_bus[LW-1:0] ^ $past(out_bus[LW-1:0])) == ~$past(in_data[LW-1:0]));
    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_bus) && !out_vld);
endmodule

// File: rtl/abt_decoder.sv
module abt_decoder
    import abt_pkg::*;
#(
    parameter int unsigned W = ABT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_bus,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    localparam int unsigned LW = W - 1;

    typedef struct packed {
        logic          vld;
        logic [LW-1:0] prev_low;
        logic [W-1:0]  data;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic [LW-1:0] mid_low;
    logic [63:0]   flip_wide;

    always_comb begin
        mid_low   = in_bus[LW-1:0] ^ st_q.prev_low;
        flip_wide = abt_guess_flip(64'(mid_low), in_bus[W-1]);
        st_d      = st_q;
        st_d.vld  = in_vld;
        if (in_vld) begin
            st_d.prev_low = in_bus[LW-1:0];
            st_d.data     = {in_bus[W-1], flip_wide[LW-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_data = st_q.data;

    // R6
    dec_msb_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_data[W-1] == $past(in_bus[W-1])) && out_vld);
    // R7
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_data) && !out_vld);
endmodule

// File: rtl/abt_codec.sv
module abt_codec
    import abt_pkg::*;
#(
    parameter int unsigned W = ABT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enc_vld,
    input  logic [W-1:0] enc_data,
    output logic         bus_vld,
    output logic [W-1:0] bus_out,
    input  logic         rx_vld,
    input  logic [W-1:0] rx_bus,
    output logic         dec_vld,
    output logic [W-1:0] dec_data
);
    abt_encoder #(.W(W)) u_enc (
        .clk(clk), .rst(rst),
        .in_vld(enc_vld), .in_data(enc_data),
        .out_vld(bus_vld), .out_bus(bus_out)
    );

    abt_decoder #(.W(W)) u_dec (
        .clk(clk), .rst(rst),
        .in_vld(rx_vld), .in_bus(rx_bus),
        .out_vld(dec_vld), .out_data(dec_data)
    );

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (bus_out == '0) && !bus_vld && (dec_data == '0) && !dec_vld);
endmodule

// File: tb/tb_abt_codec.sv
module tb_abt_codec;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enc_vld = 1'b0;
    logic [W-1:0] enc_data = '0;
    logic         bus_vld, dec_vld;
    logic [W-1:0] bus_out, dec_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [W-2:0] m_prev = '0;
    logic [W-1:0] m_bus = '0;
    logic         m_pv = 1'b0;
    logic [W-1:0] m_pd = '0;
    logic [W-1:0] m_out = '0;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    abt_codec #(.W(W)) dut (
        .clk(clk), .rst(rst),
        .enc_vld(enc_vld), .enc_data(enc_data),
        .bus_vld(bus_vld), .bus_out(bus_out),
        .rx_vld(bus_vld), .rx_bus(bus_out),
        .dec_vld(dec_vld), .dec_data(dec_data)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check the result at the next negedge.
    task automatic step(input logic v, input logic [W-1:0] d);
        logic [W-2:0] low;
        enc_vld  = v;
        enc_data = d;
        if (v) begin
            low    = d[W-1] ? ~d[W-2:0] : d[W-2:0];
            m_bus  = {d[W-1], low ^ m_prev};
            m_prev = m_bus[W-2:0];
        end
        @(negedge clk);
        if (v) chk(d[W-1] ? "R4 bus word (msb 1, R2)" : "R3 bus word (msb 0, R2)", bus_out, m_bus);
        else   chk("R5 bus held on idle", bus_out, m_bus);
        chk("R2/R5 bus_vld", {7'b0, bus_vld}, {7'b0, v});
        if (m_pv) m_out = m_pd;
        chk(m_pv ? "R6 decoded word" : "R7 decoded word held", dec_data, m_out);
        chk("R6/R7 dec_vld", {7'b0, dec_vld}, {7'b0, m_pv});
        m_pv = v;
        m_pd = d;
    endtask

    task automatic nxt_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 bus_out in reset", bus_out, '0);
        chk("R1 dec_data in reset", dec_data, '0);
        chk("R1 valids in reset", {6'b0, bus_vld, dec_vld}, '0);
        rst = 1'b0;
        // R8 worked example
        step(1'b1, 8'b00000101);
        chk("R8 first bus word", bus_out, 8'b00000101);
        step(1'b1, 8'b10101111);
        chk("R8 second bus word", bus_out, 8'b11010101);
        step(1'b0, '0);
        step(1'b0, '0);
        // ascending sweep, back to back
        for (int i = 0; i < 256; i++) step(1'b1, W'(i));
        // descending sweep with idle gaps (R5, R7)
        for (int i = 255; i >= 0; i--) begin
            step(1'b1, W'(i));
            if (i % 3 == 0) step(1'b0, W'(i * 7));
        end
        // sign piece / fraction piece alternation
        for (int i = 0; i < 3000; i++) begin
            nxt_rand();
            step(1'b1, lfsr[3] ? 8'hFF : 8'h00);
            step(1'b1, lfsr[15:8]);
        end
        // pseudo-random words with random valid
        for (int i = 0; i < 6000; i++) begin
            nxt_rand();
            step(lfsr[0] | lfsr[5], lfsr[23:16]);
        end
        step(1'b0, '0);
        step(1'b0, '0);
        // reset mid-stream clears everything (R1)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 bus_out after reset", bus_out, '0);
        chk("R1 dec_data after reset", dec_data, '0);
        m_prev = '0; m_bus = '0; m_pv = 1'b0; m_out = '0;
        step(1'b1, 8'b00000101);
        chk("R8 after re-reset", bus_out, 8'b00000101);
        step(1'b1, 8'b10101111);
        step(1'b0, '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule